// File: doc/BRIEF.md
# Infrared Pulse Encoder/Decoder

This block sits between the serial bit stream of a UART and an infrared transceiver. It is paced by a 16x oversampling enable, `tick16`, which is high for one clock cycle per sixteenth of a bit. A mode bit, `ir_en`, selects the infrared mode. When `ir_en` is 0, both directions pass straight through as ordinary NRZ. When `ir_en` is 1, the transmit side sends each zero bit as one short high pulse of three ticks, placed just before the middle of the bit cell. The receive side stretches each detected light pulse back into a full low bit cell. Both pins idle low in infrared mode. A second bit, `rx_invert`, flips the raw receive pin before decoding, for transceivers that report light as a low level.

The transmit path is a four-state machine with these states:
- `E_IDLE`: the pin is low.
- `E_DELAY`: counting ticks up to the pulse window.
- `E_PULSE`: the pin is high.
- `E_REST`: the remainder of the cell.

Its transitions are:
- `E_IDLE`→`E_DELAY` on a tick that sees a zero data bit. That tick is phase 0 of the cell.
- `E_DELAY`→`E_PULSE` when the phase reaches 7.
- `E_PULSE`→`E_REST` when the phase reaches 10.
- `E_REST`→`E_DELAY` or `E_IDLE` on the tick that opens the next cell. The choice depends on whether the new bit is 0 or 1.

The receive path has two states, `D_IDLE` and `D_HOLD`. A tick that samples the decoded input high moves it `D_IDLE`→`D_HOLD`. In `D_HOLD`, the sixteenth tick after detection either re-arms the state (`D_HOLD`→`D_HOLD`, when a new pulse is present) or returns it to `D_IDLE`. Forcing `ir_en` low returns both machines to idle.

Top module: `ir_codec`

## Requirements
- R1: With `ir_en`=0, `tx_pin` equals `tx_nrz` and `rx_nrz` equals `rx_pin` in the same cycle, with no register in either path.
- R2: With `ir_en`=1 and `tx_nrz` held at 1 across whole bit cells, `tx_pin` stays at 0.
- R3: With `ir_en`=1, a zero data bit produces exactly one high pulse on `tx_pin`, and that pulse lasts 3 ticks.
- R4: Phases are numbered 0 to 15 within the cell, where phase 0 is the tick on which the zero bit is first sampled. `tx_pin` is 1 after the ticks of phases 7, 8 and 9, and 0 after every other tick of the cell. It changes only on the clock edge that consumes a tick.
- R5: Back-to-back zero bits give one pulse per cell, with the pulses 16 ticks apart.
- R6: With `ir_en`=1, a tick that samples (`rx_pin` XOR `rx_invert`)=1 while the decoder is idle drives `rx_nrz` to 0 from that clock edge.
- R7: After a detection, `rx_nrz` stays 0 through the following 15 ticks. On the 16th tick it returns to 1 unless a pulse is sampled on that same tick, in which case it stays 0 for another 16 ticks.
- R8: With `rx_invert`=1, low-going pulses on `rx_pin` decode the same way as high-going pulses do with `rx_invert`=0, and a constantly high `rx_pin` decodes as 1.
- R9: During and after reset with `ir_en`=1 and `rx_pin` low, `tx_pin` is 0 and `rx_nrz` is 1.
- R10: With `ir_en`=1, `tx_pin` and `rx_nrz` change only on the clock edge that follows a cycle with `tick16` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_en | input | 1 | 1 selects infrared pulse mode, 0 selects NRZ pass-through |
| rx_invert | input | 1 | Inverts `rx_pin` before decoding in infrared mode |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| tx_nrz | input | 1 | NRZ transmit bit from the UART |
| tx_pin | output | 1 | Drive to the infrared transmitter |
| rx_pin | input | 1 | Signal from the infrared receiver |
| rx_nrz | output | 1 | Decoded NRZ bit to the UART receiver |

## Verification
The hardest case to reach from the ports is the `D_HOLD` re-arm. A second pulse has to be sampled on exactly the sixteenth tick after the first detection, so the hold chains without a single high cycle on `rx_nrz`. The bench reaches it by driving `rx_pin` from a tick-indexed bit mask, with pulses at ticks 7–9 and again at 23–25. A reference counter built from R7 predicts the output after every tick. The same masks are replayed with `rx_invert` set and the pin levels flipped. The encoder's cell wrap from `E_REST` is reached by holding two zero bits in a row and checking every tick.

// File: rtl/ir_codec_pkg.sv
package ir_codec_pkg;

    typedef enum logic [1:0] {
        E_IDLE,
        E_DELAY,
        E_PULSE,
        E_REST
    } enc_state_t;

    typedef enum logic {
        D_IDLE,
        D_HOLD
    } dec_state_t;

endpackage

// File: rtl/ir_pulse_enc.sv
module ir_pulse_enc
    import ir_codec_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int PULSE_START = 7,
    parameter int PULSE_LEN   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic nrz_in,
    output logic pulse_out
);
    localparam int PW = $clog2(OSR);
    localparam logic [PW-1:0] START_PH = PW'(PULSE_START);
    localparam logic [PW-1:0] END_PH   = PW'(PULSE_START + PULSE_LEN);
    localparam logic [PW-1:0] LAST_PH  = PW'(OSR - 1);

    enc_state_t      state, nstate;
    logic [PW-1:0]   phase, nphase;
    logic [PW-1:0]   step;
    logic            pulse_q;

    always_comb begin
        nstate = state;
        nphase = phase;
        step   = phase + 1'b1;
        if (tick) begin
            unique case (state)
                E_IDLE: begin
                    if (!nrz_in) begin
                        nstate = E_DELAY;
                        nphase = '0;
                    end
                end
                E_DELAY: begin
                    nphase = step;
                    if (step == START_PH) nstate = E_PULSE;
                end
                E_PULSE: begin
                    nphase = step;
                    if (step == END_PH) nstate = E_REST;
                end
                E_REST: begin
                    if (phase == LAST_PH) begin
                        nphase = '0;
                        nstate = nrz_in ? E_IDLE : E_DELAY;
                    end else begin
                        nphase = step;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state <= E_IDLE;
            phase <= '0;
        end else begin
            state <= nstate;
            phase <= nphase;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= run && (nstate == E_PULSE);
    end

    assign pulse_out = pulse_q;

endmodule

// File: rtl/ir_pulse_dec.sv
module ir_pulse_dec
    import ir_codec_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic pulse_in,
    output logic nrz_out
);
    localparam int PW = $clog2(OSR);
    localparam logic [PW-1:0] LAST_CNT = PW'(OSR - 1);

    dec_state_t    state, nstate;
    logic [PW-1:0] cnt, ncnt;
    logic          nrz_q;

    always_comb begin
        nstate = state;
        ncnt   = cnt;
        if (tick) begin
            unique case (state)
                D_IDLE: begin
                    if (pulse_in) begin
                        nstate = D_HOLD;
                        ncnt   = '0;
                    end
                end
                D_HOLD: begin
                    if (cnt == LAST_CNT) begin
                        ncnt   = '0;
                        nstate = pulse_in ? D_HOLD : D_IDLE;
                    end else begin
                        ncnt = cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state <= D_IDLE;
            cnt   <= '0;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) nrz_q <= 1'b1;
        else        nrz_q <= !(run && (nstate == D_HOLD));
    end

    assign nrz_out = nrz_q;

endmodule

// File: rtl/ir_codec.sv
module ir_codec #(
    parameter int OSR         = 16,
    parameter int PULSE_START = 7,
    parameter int PULSE_LEN   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_en,
    input  logic rx_invert,
    input  logic tick16,
    input  logic tx_nrz,
    output logic tx_pin,
    input  logic rx_pin,
    output logic rx_nrz
);
    logic enc_pulse;
    logic dec_nrz;
    logic rx_sense;

    assign rx_sense = rx_pin ^ rx_invert;

    ir_pulse_enc #(
        .OSR        (OSR),
        .PULSE_START(PULSE_START),
        .PULSE_LEN  (PULSE_LEN)
    ) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ir_en),
        .tick     (tick16),
        .nrz_in   (tx_nrz),
        .pulse_out(enc_pulse)
    );

    ir_pulse_dec #(
        .OSR(OSR)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ir_en),
        .tick    (tick16),
        .pulse_in(rx_sense),
        .nrz_out (dec_nrz)
    );

    assign tx_pin = ir_en ? enc_pulse : tx_nrz;
    assign rx_nrz = ir_en ? dec_nrz   : rx_pin;

endmodule

// File: rtl/ir_codec_chk.sv
module ir_codec_chk #(
    parameter int PULSE_LEN = 3
) (
    input logic clk,
    input logic rst_n,
    input logic ir_en,
    input logic rx_invert,
    input logic tick16,
    input logic tx_nrz,
    input logic tx_pin,
    input logic rx_pin,
    input logic rx_nrz
);
    logic [7:0] hi_ticks;

    always_ff @(posedge clk) begin
        if (!rst_n || !ir_en || !tx_pin) hi_ticks <= '0;
        else if (tick16 && hi_ticks != 8'hFF) hi_ticks <= hi_ticks + 1'b1;
    end

    assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_en |-> (tx_pin == tx_nrz && rx_nrz == rx_pin));

    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_ticks <= 8'(PULSE_LEN));

    assert_rise_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_en && $past(ir_en) && $past(rst_n) && $rose(tx_pin)) |-> $past(tick16));

    assert_detect_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_en && $past(ir_en) && $past(rst_n) && $past(tick16)
         && $past(rx_pin ^ rx_invert)) |-> !rx_nrz);

    assert_tick_paced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_en && $past(ir_en) && $past(rst_n) && !$past(tick16))
        |-> ($stable(tx_pin) && $stable(rx_nrz)));

endmodule

bind ir_codec ir_codec_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ir_en    (ir_en),
    .rx_invert(rx_invert),
    .tick16   (tick16),
    .tx_nrz   (tx_nrz),
    .tx_pin   (tx_pin),
    .rx_pin   (rx_pin),
    .rx_nrz   (rx_nrz)
);

// File: tb/sim_ir_codec.sv
`timescale 1ns/1ps
module sim_ir_codec;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ir_en = 1'b1;
    logic rx_invert = 1'b0;
    logic tick16 = 1'b0;
    logic tx_nrz = 1'b1;
    logic rx_pin = 1'b0;
    logic tx_pin;
    logic rx_nrz;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    ir_codec u0 (
        .clk(clk), .rst_n(rst_n), .ir_en(ir_en), .rx_invert(rx_invert),
        .tick16(tick16), .tx_nrz(tx_nrz), .tx_pin(tx_pin),
        .rx_pin(rx_pin), .rx_nrz(rx_nrz)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // one tick pulse, then sample at the following negedge
    task automatic do_tick();
        @(negedge clk) tick16 = 1'b1;
        @(negedge clk) tick16 = 1'b0;
    endtask

    task automatic test_reset();
        chk("R9 tx_pin in reset", tx_pin, 1'b0);
        chk("R9 rx_nrz in reset", rx_nrz, 1'b1);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 tx_pin after reset", tx_pin, 1'b0);
        chk("R9 rx_nrz after reset", rx_nrz, 1'b1);
    endtask

    task automatic test_passthru();
        @(negedge clk) ir_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tx_nrz = i[0];
            rx_pin = i[1];
            #1;
            chk("R1 tx pass", tx_pin, i[0]);
            chk("R1 rx pass", rx_nrz, i[1]);
            @(negedge clk);
        end
        tx_nrz = 1'b1;
        rx_pin = 1'b0;
        ir_en  = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // bits[c] is the data bit of cell c; every tick is checked
    task automatic tx_cells(input string req, input logic [3:0] bits, input int ncells);
        for (int c = 0; c < ncells; c++) begin
            for (int ph = 0; ph < 16; ph++) begin
                tx_nrz = bits[c];
                do_tick();
                chk(req, tx_pin, !bits[c] && ph >= 7 && ph <= 9);
            end
        end
        tx_nrz = 1'b1;
    endtask

    // mask bit k is the decoded-sense level at tick k; model follows R6/R7
    task automatic rx_run(input string req, input logic [39:0] mask, input logic inv);
        int rem = 0;
        rx_invert = inv;
        for (int k = 0; k < 40; k++) begin
            rx_pin = mask[k] ^ inv;
            if (rem == 0) begin
                if (mask[k]) rem = 16;
            end else begin
                rem--;
                if (rem == 0 && mask[k]) rem = 16;
            end
            do_tick();
            chk(req, rx_nrz, rem == 0);
            @(negedge clk);
            chk("R10 rx_nrz held between ticks", rx_nrz, rem == 0);
        end
        rx_pin = inv;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_passthru();
        tx_cells("R3 R4 single zero bit", 4'b1110, 2);
        tx_cells("R5 R2 two zeros then ones", 4'b1100, 4);
        rx_run("R6 R7 single pulse", 40'h00_0000_0380, 1'b0);
        rx_run("R7 chained pulses", 40'h00_0380_0380, 1'b0);
        rx_run("R8 inverted pulses", 40'h00_0380_0380, 1'b1);
        rx_run("R8 inverted idle high", 40'h0, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule